// File: doc/BRIEF.md
# Uncorrectable-Error Read Retry Controller

This block sits between a requester and a memory read port. The read port returns one complete cache line per response, together with a two-bit ECC status from an external decoder. The controller tracks a single outstanding read. A demand read can come back uncorrectable while retry is enabled. In that case the controller issues the same line request to memory a second time, and it never issues a third. If the second attempt is clean or corrected, its data goes to the requester as a normal response. If the second attempt is also uncorrectable, the controller writes the line address into an error log and raises a one-cycle escalation pulse.

Scrub reads are never retried. An uncorrectable scrub result is returned with a speculative tag. It does not escalate and it does not touch the log. Clearing the retry-enable bit makes the first uncorrectable demand result escalate at once. The log keeps the first confirmed failure until software clears it.

Top module: `ue_retry_ctrl`

## Requirements
- R1: A demand read (`req_scrub`=0) whose first response has `mem_rsp_ecc[1]`=1 while `cfg_retry_en`=1 causes exactly two memory requests. A scrub read (`req_scrub`=1) always causes exactly one.
- R2: Every memory request carries the line address of the request: `req_addr` with its low `LINE_OFS` bits forced to zero. A retry carries the same address as the first attempt.
- R3: A read is retried at most once. An uncorrectable result on the retry ends the transaction without a third memory request.
- R4: When the retry is also uncorrectable, the response has `rsp_err`=1, `esc_pulse` fires and the log records the line address.
- R5: With `cfg_retry_en`=0, the first uncorrectable demand result gets no retry and is escalated and logged immediately.
- R6: An uncorrectable scrub result is returned with `rsp_err`=1 and `rsp_spec`=1. It produces no `esc_pulse` and leaves `log_valid` and `log_addr` unchanged.
- R7: When the retry returns clean (`ecc`=00) or corrected (`ecc`=01) data, that attempt's data is forwarded with `rsp_err`=0. Nothing is escalated or logged.
- R8: `req_ready` is low from the cycle after a request is accepted until the cycle in which `rsp_valid` is high. Only one read is outstanding at a time.
- R9: `log_valid` is sticky and `log_addr` holds the first confirmed failing line address. A one-cycle `log_clr` clears the flag. A confirmed error on the same edge as `log_clr` wins and is captured.
- R10: `esc_pulse` is high for exactly one cycle per confirmed error, in the same cycle as that read's `rsp_valid`.
- R11: After reset, `req_ready`=1 and `mem_req_valid`, `rsp_valid`, `esc_pulse` and `log_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_retry_en | input | 1 | Enables the single retry of uncorrectable demand reads |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ADDR_W | Byte address of the read |
| req_scrub | input | 1 | 1 = scrub read, 0 = demand read |
| mem_req_valid | output | 1 | Line request to memory |
| mem_req_ready | input | 1 | Memory accepts the line request |
| mem_req_addr | output | ADDR_W | Line-aligned address sent to memory |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_data | input | DATA_W | Cache line data |
| mem_rsp_ecc | input | 2 | bit1 = uncorrectable, bit0 = corrected |
| rsp_valid | output | 1 | Final response valid (one cycle) |
| rsp_data | output | DATA_W | Final line data |
| rsp_err | output | 1 | Final data is uncorrectable |
| rsp_spec | output | 1 | Uncorrectable scrub result (speculative) |
| log_valid | output | 1 | Error log holds a confirmed failure |
| log_addr | output | ADDR_W | Line address of the logged failure |
| log_clr | input | 1 | Write-one-to-clear of `log_valid` |
| esc_pulse | output | 1 | One-cycle escalation of a confirmed error |

## Verification
The hardest case to reach from the ports is a software clear landing on the same clock edge as a confirmed double failure. Reaching it needs two uncorrectable attempts in a row, with the clear aligned to the exact cycle in which the second response arrives. The bench plays the memory side itself. It assigns an ECC status to each attempt separately and can raise `log_clr` together with the final response. Randomized ready stalls and response latencies, mixed with random retry-enable and scrub settings, then cover the remaining orderings.

// File: rtl/ue_retry_pkg.sv
package ue_retry_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ISSUE,
      ST_WAIT,
      ST_REISSUE,
      ST_REWAIT
   } rr_state_e;

   // ECC status: bit 1 marks uncorrectable data, bit 0 a corrected one.
   function automatic logic ecc_is_ue(input logic [1:0] st);
      return st[1];
   endfunction

endpackage

// File: rtl/ue_retry_fsm.sv
module ue_retry_fsm
   import ue_retry_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int LINE_OFS = 6,
   parameter int DATA_W   = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_retry_en,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_scrub,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data,
   input  logic [1:0]        mem_rsp_ecc,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_err,
   output logic              rsp_spec,
   output logic              confirm,
   output logic [ADDR_W-1:0] confirm_addr
);

   rr_state_e         state, state_nx;
   logic [ADDR_W-1:0] line_in, addr_q;
   logic              scrub_q;
   logic              rsp_ue, want_retry, final_rsp, accept;

   generate
      if (LINE_OFS == 0) begin : g_noalign
         assign line_in = req_addr;
      end else begin : g_align
         assign line_in = {req_addr[ADDR_W-1:LINE_OFS], {LINE_OFS{1'b0}}};
      end
   endgenerate

   assign req_ready     = (state == ST_IDLE);
   assign accept        = req_valid && req_ready;
   assign mem_req_valid = (state == ST_ISSUE) || (state == ST_REISSUE);
   assign mem_req_addr  = addr_q;
   assign rsp_ue        = ecc_is_ue(mem_rsp_ecc);
   assign want_retry    = (state == ST_WAIT) && mem_rsp_valid && rsp_ue
                          && !scrub_q && cfg_retry_en;
   assign final_rsp     = mem_rsp_valid &&
                          ((state == ST_REWAIT) || ((state == ST_WAIT) && !want_retry));
   assign confirm       = final_rsp && rsp_ue && !scrub_q;
   assign confirm_addr  = addr_q;

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:    if (accept) state_nx = ST_ISSUE;
         ST_ISSUE:   if (mem_req_ready) state_nx = ST_WAIT;
         ST_WAIT:    if (want_retry) state_nx = ST_REISSUE;
                     else if (mem_rsp_valid) state_nx = ST_IDLE;
         ST_REISSUE: if (mem_req_ready) state_nx = ST_REWAIT;
         ST_REWAIT:  if (mem_rsp_valid) state_nx = ST_IDLE;
         default:    state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         addr_q    <= '0;
         scrub_q   <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
         rsp_err   <= 1'b0;
         rsp_spec  <= 1'b0;
      end else begin
         state     <= state_nx;
         rsp_valid <= final_rsp;
         if (accept) begin
            addr_q  <= line_in;
            scrub_q <= req_scrub;
         end
         if (final_rsp) begin
            rsp_data <= mem_rsp_data;
            rsp_err  <= rsp_ue;
            rsp_spec <= rsp_ue && scrub_q;
         end
      end
   end

   // R1
   scrub_no_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && mem_rsp_valid && scrub_q) |=> (state == ST_IDLE));
   // R3
   single_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_REWAIT && mem_rsp_valid) |=> (state == ST_IDLE));
   // R5
   retry_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && mem_rsp_valid && !cfg_retry_en) |=> !mem_req_valid);
   // R8
   busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !req_ready);
   // R2
   retry_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_REISSUE && $past(state) == ST_WAIT) |-> $stable(mem_req_addr));

endmodule

// File: rtl/ue_retry_log.sv
module ue_retry_log #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              confirm,
   input  logic [ADDR_W-1:0] confirm_addr,
   input  logic              log_clr,
   output logic              log_valid,
   output logic [ADDR_W-1:0] log_addr,
   output logic              esc_pulse
);

   logic capture;
   assign capture = confirm && (!log_valid || log_clr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         log_valid <= 1'b0;
         log_addr  <= '0;
         esc_pulse <= 1'b0;
      end else begin
         esc_pulse <= confirm;
         if (capture) begin
            log_valid <= 1'b1;
            log_addr  <= confirm_addr;
         end else if (log_clr) begin
            log_valid <= 1'b0;
         end
      end
   end

   // R10
   esc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      esc_pulse |=> !esc_pulse);
   // R9
   esc_logged_chk: assert property (@(posedge clk) disable iff (!rst_n)
      esc_pulse |-> log_valid);
   // R9
   log_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (log_valid && !log_clr) |=> (log_valid && $stable(log_addr)));

endmodule

// File: rtl/ue_retry_ctrl.sv
module ue_retry_ctrl #(
   parameter int ADDR_W   = 32,
   parameter int LINE_OFS = 6,
   parameter int DATA_W   = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_retry_en,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_scrub,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data,
   input  logic [1:0]        mem_rsp_ecc,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_err,
   output logic              rsp_spec,
   output logic              log_valid,
   output logic [ADDR_W-1:0] log_addr,
   input  logic              log_clr,
   output logic              esc_pulse
);

   generate
      if (LINE_OFS < 0 || LINE_OFS >= ADDR_W) begin : g_bad_ofs
         $error("LINE_OFS must lie in 0..ADDR_W-1");
      end
      if (DATA_W < 1) begin : g_bad_dw
         $error("DATA_W must be positive");
      end
   endgenerate

   logic              confirm;
   logic [ADDR_W-1:0] confirm_addr;

   ue_retry_fsm #(
      .ADDR_W  (ADDR_W),
      .LINE_OFS(LINE_OFS),
      .DATA_W  (DATA_W)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_retry_en (cfg_retry_en),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .req_addr     (req_addr),
      .req_scrub    (req_scrub),
      .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready),
      .mem_req_addr (mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data (mem_rsp_data),
      .mem_rsp_ecc  (mem_rsp_ecc),
      .rsp_valid    (rsp_valid),
      .rsp_data     (rsp_data),
      .rsp_err      (rsp_err),
      .rsp_spec     (rsp_spec),
      .confirm      (confirm),
      .confirm_addr (confirm_addr)
   );

   ue_retry_log #(
      .ADDR_W(ADDR_W)
   ) u_log (
      .clk         (clk),
      .rst_n       (rst_n),
      .confirm     (confirm),
      .confirm_addr(confirm_addr),
      .log_clr     (log_clr),
      .log_valid   (log_valid),
      .log_addr    (log_addr),
      .esc_pulse   (esc_pulse)
   );

   // R10
   esc_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      esc_pulse |-> (rsp_valid && rsp_err && !rsp_spec));
   // R8
   rsp_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> req_ready);
   // R6
   spec_no_esc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_spec |-> !esc_pulse);

endmodule

// File: tb/ue_retry_ctrl_bench.sv
module ue_retry_ctrl_bench;

   localparam int AW  = 32;
   localparam int OFS = 6;
   localparam int DW  = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_retry_en = 1'b1;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic          req_scrub = 1'b0;
   logic          mem_req_valid;
   logic          mem_req_ready = 1'b0;
   logic [AW-1:0] mem_req_addr;
   logic          mem_rsp_valid = 1'b0;
   logic [DW-1:0] mem_rsp_data = '0;
   logic [1:0]    mem_rsp_ecc = 2'b00;
   logic          rsp_valid;
   logic [DW-1:0] rsp_data;
   logic          rsp_err, rsp_spec;
   logic          log_valid;
   logic [AW-1:0] log_addr;
   logic          log_clr = 1'b0;
   logic          esc_pulse;

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;

   logic          m_log_v = 1'b0;
   logic [AW-1:0] m_log_a = '0;

   always #2 clk = ~clk;

   ue_retry_ctrl #(.ADDR_W(AW), .LINE_OFS(OFS), .DATA_W(DW)) u_ue_retry_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_retry_en(cfg_retry_en),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_scrub(req_scrub), .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .mem_rsp_ecc(mem_rsp_ecc), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .rsp_err(rsp_err), .rsp_spec(rsp_spec), .log_valid(log_valid),
      .log_addr(log_addr), .log_clr(log_clr), .esc_pulse(esc_pulse)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cycles);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] line_of(input logic [AW-1:0] a);
      return {a[AW-1:OFS], {OFS{1'b0}}};
   endfunction

   function automatic logic [DW-1:0] line_data(input logic [AW-1:0] a, input int att);
      return {a ^ 32'h5A5A_0F0F, 32'hC0DE_0000 | att};
   endfunction

   task automatic run_txn(input logic [AW-1:0] a, input bit scr, input bit en,
                          input logic [1:0] e1, input logic [1:0] e2, input bit clr_final);
      bit            do_retry = !scr && en && e1[1];
      int            exp_n    = do_retry ? 2 : 1;
      logic [1:0]    fin_ecc  = do_retry ? e2 : e1;
      bit            exp_esc  = !scr && fin_ecc[1];
      logic [AW-1:0] ln       = line_of(a);
      int            nreq = 0;
      int            cnt  = -1;
      bit            got  = 0;
      bit            busy_bad = 0;
      bit            addr_bad = 0;
      logic [DW-1:0] g_data = '0;
      bit            g_err = 0, g_spec = 0, g_esc = 0;
      @(negedge clk);
      cfg_retry_en = en; req_addr = a; req_scrub = scr; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      for (int cyc = 0; cyc < 60; cyc++) begin
         if (mem_rsp_valid) begin
            mem_rsp_valid = 1'b0;
            log_clr = 1'b0;
         end
         if (rsp_valid) begin
            got = 1; g_data = rsp_data; g_err = rsp_err; g_spec = rsp_spec;
            g_esc = esc_pulse;
            break;
         end
         if (req_ready) busy_bad = 1;
         if (cnt > 0) cnt--;
         else if (cnt == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = line_data(ln, nreq);
            mem_rsp_ecc   = (nreq == 1) ? e1 : e2;
            if (clr_final && nreq == exp_n) log_clr = 1'b1;
            cnt = -1;
         end
         mem_req_ready = ($urandom % 3) != 0;
         if (mem_req_valid && mem_req_ready) begin
            nreq++;
            if (mem_req_addr != ln) addr_bad = 1;
            cnt = $urandom % 3;
         end
         @(negedge clk);
      end
      mem_req_ready = 1'b0;
      chk(got, "R8 response seen", 64'(got), 64'd1);
      // R1 R3 R5: number of memory requests
      chk(nreq == exp_n, "R1/R3/R5 memory request count", 64'(nreq), 64'(exp_n));
      chk(!addr_bad, "R2 line address of every attempt", 64'(addr_bad), 64'd0);
      chk(!busy_bad, "R8 ready low while busy", 64'(busy_bad), 64'd0);
      chk(g_data == line_data(ln, exp_n), "R7 data of final attempt", g_data,
          line_data(ln, exp_n));
      chk(g_err == fin_ecc[1], "R4/R7 rsp_err", 64'(g_err), 64'(fin_ecc[1]));
      chk(g_spec == (scr && e1[1]), "R6 rsp_spec", 64'(g_spec), 64'(scr && e1[1]));
      chk(g_esc == exp_esc, "R10/R4/R5 esc_pulse with response", 64'(g_esc), 64'(exp_esc));
      if (clr_final) begin
         m_log_v = exp_esc;
         if (exp_esc) m_log_a = ln;
      end else if (exp_esc && !m_log_v) begin
         m_log_v = 1'b1;
         m_log_a = ln;
      end
      @(negedge clk);
      chk(!esc_pulse, "R10 pulse one cycle", 64'(esc_pulse), 64'd0);
      chk(log_valid == m_log_v, "R9/R6 log_valid", 64'(log_valid), 64'(m_log_v));
      if (m_log_v)
         chk(log_addr == m_log_a, "R9/R4 log_addr", 64'(log_addr), 64'(m_log_a));
   endtask

   task automatic clear_log();
      @(negedge clk); log_clr = 1'b1;
      @(negedge clk); log_clr = 1'b0;
      m_log_v = 1'b0;
      chk(!log_valid, "R9 clear by log_clr", 64'(log_valid), 64'd0);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(req_ready, "R11 req_ready after reset", 64'(req_ready), 64'd1);
      chk(!mem_req_valid && !rsp_valid && !esc_pulse && !log_valid,
          "R11 outputs idle after reset",
          64'({mem_req_valid, rsp_valid, esc_pulse, log_valid}), 64'd0);
      run_txn(32'h0000_1234, 0, 1, 2'b00, 2'b00, 0);  // R7 clean, no retry
      run_txn(32'h0000_2240, 0, 1, 2'b10, 2'b00, 0);  // R1 R7 retry clean
      run_txn(32'h0000_3310, 0, 1, 2'b10, 2'b01, 0);  // R7 retry corrected
      run_txn(32'h0000_4480, 0, 1, 2'b10, 2'b10, 0);  // R3 R4 confirmed
      run_txn(32'h0000_5500, 0, 1, 2'b11, 2'b10, 0);  // R9 log keeps first
      run_txn(32'h0000_6600, 1, 1, 2'b10, 2'b10, 0);  // R6 scrub UE
      clear_log();
      run_txn(32'h0000_7700, 0, 0, 2'b10, 2'b00, 0);  // R5 retry off
      run_txn(32'h0000_8800, 1, 0, 2'b10, 2'b00, 0);  // R6 scrub, retry off
      run_txn(32'h0000_9900, 0, 1, 2'b10, 2'b10, 1);  // R9 clear vs capture
      run_txn(32'h0000_AA00, 0, 1, 2'b00, 2'b00, 1);  // R9 clear alone
      for (int i = 0; i < 400; i++) begin
         logic [1:0] e1 = ($urandom % 2) ? 2'b10 : 2'($urandom % 4);
         logic [1:0] e2 = 2'($urandom % 4);
         run_txn($urandom, ($urandom % 4) == 0, ($urandom % 5) != 0, e1, e2,
                 ($urandom % 16) == 0);
         if (($urandom % 20) == 0) clear_log();
      end
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule